// File: doc/BRIEF.md
# Shared-Line Serial ADC Host Controller

This block is the host side of a three-wire link to a two-channel 12-bit serial converter. The link has a chip select, a serial clock and one bidirectional data line. A one-cycle start request latches a 3-bit configuration word, which picks the converter's channel and mode. The controller then pulls chip select low and sends a logic-1 start bit followed by the configuration bits, most significant first. After that it lets go of the data line so the converter can answer on the same wire.

The converter replies with one null bit and then twelve result bits, MSB first. The host checks the null bit and collects the result. When the serial clock has run 17 pulses, the host raises chip select and presents the result with a one-cycle done pulse. The serial clock is derived from the system clock. Each half period lasts `div_half` system clocks, and a value of 0 counts as 1. A minimum chip-select-high time, counted in system clocks, separates consecutive frames.

Top module: `adc3w_host`

## Requirements
- R1: While chip select is high (after reset and between frames), `sclk` is low and `sdata_oe` is low.
- R2: A frame opens with `cs_n` falling and the host driving 1 on the data line. The host then drives the latched `cfg` word as three bits, `cfg[2]` first and `cfg[0]` last, so the converter captures start bit 1 and the exact configuration.
- R3: Each `sclk` half period is max(`div_half`,1) system clocks, and a frame has exactly 17 rising edges. While chip select is low, `sdata_o` changes only on a falling edge of `sclk`, never while `sclk` is high and never on a rising edge.
- R4: The host drives the line for the first 4 rising edges only (start plus configuration). It releases the line on the falling edge after the 4th rise, before the null bit, and never drives while chip select is high.
- R5: The line level captured at the 5th rising edge is the null bit. `null_err`, updated with the result, is 1 exactly when that bit read 1.
- R6: The bits captured at rising edges 6 through 17 form `result`, the first of them being bit 11 (MSB first).
- R7: `busy` goes high the cycle after a start request and falls in the cycle `done` pulses. `done` is high for exactly one cycle, with `cs_n` already high.
- R8: A start request while `busy` is high is ignored: the running frame keeps its configuration and no extra frame follows.
- R9: Chip select stays high for at least `CS_HIGH_MIN` system clocks between frames. A start request issued in the done cycle brings the next falling edge of `cs_n` exactly `CS_HIGH_MIN`+1 cycles after the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_half | input | DIV_W | Serial clock half period in system clocks (0 treated as 1) |
| start | input | 1 | One-cycle conversion request |
| cfg | input | CFG_W | Channel/mode word sent after the start bit |
| busy | output | 1 | High from accepted request until done |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | RES_W | Last conversion result |
| null_err | output | 1 | Null bit of the last frame read 1 |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| sdata_o | output | 1 | Value driven onto the shared data line |
| sdata_oe | output | 1 | Drive enable for the shared data line |
| sdata_i | input | 1 | Level read back from the shared data line |

## Verification
The bench models the converter on a pulled-up shared line. If the host released the line too early, the null bit would read the pull-up and `null_err` would be set. If it released too late, both sides would drive the line at once, which the bench reports as contention. Divider value 0 and odd divider values are exercised. A wrong half-period count shows up in the measured total `sclk` high time, and an off-by-one in the bit index shows up as a wrong rising-edge count or a result shifted by one bit. A start request in the middle of a frame and a request issued in the done cycle expose a controller that restarts or corrupts its configuration, and one that shortens the chip-select-high gap.

// File: rtl/adc3w_pkg.sv
package adc3w_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER} adc3w_state_e;

  // effective half period of the serial clock
  function automatic int unsigned half_limit(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // command bit for serial slot idx (1..cfg_w), MSB of the word first
  function automatic logic cmd_bit(input logic [7:0] word, input int unsigned idx,
                                   input int unsigned cfg_w);
    return word[cfg_w - idx];
  endfunction
endpackage

// File: rtl/adc3w_sclk_gen.sv
module adc3w_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_half,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt
);
  import adc3w_pkg::*;

  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt;
  logic             edge_evt;

  assign lim      = DIV_W'(half_limit(int'(div_half)));
  assign edge_evt = en && (cnt == lim - 1'b1);
  assign rise_evt = edge_evt && !sclk;
  assign fall_evt = edge_evt && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (edge_evt) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt < lim); // R3
endmodule

// File: rtl/adc3w_rx_shift.sv
module adc3w_rx_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (clr)      q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/adc3w_host.sv
module adc3w_host #(
  parameter int DIV_W       = 8,
  parameter int RES_W       = 12,
  parameter int CFG_W       = 3,
  parameter int CS_HIGH_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             null_err,
  output logic             cs_n,
  output logic             sclk,
  output logic             sdata_o,
  output logic             sdata_oe,
  input  logic             sdata_i
);
  import adc3w_pkg::*;

  localparam int NULL_IDX = CFG_W + 1;
  localparam int LAST_IDX = NULL_IDX + RES_W;
  localparam int IDX_W    = $clog2(LAST_IDX + 1);
  localparam int GAP_W    = $clog2(CS_HIGH_MIN + 2);
  localparam logic [IDX_W-1:0] NULL_I = IDX_W'(NULL_IDX);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(LAST_IDX);
  localparam logic [IDX_W-1:0] CFG_I  = IDX_W'(CFG_W);

  adc3w_state_e     state;
  logic [IDX_W-1:0] bit_idx;
  logic [CFG_W-1:0] cfg_q;
  logic [GAP_W-1:0] gap_cnt;
  logic             nerr_q;
  logic [RES_W-1:0] rx_q;

  // named internal events
  logic in_xfer, rise_evt, fall_evt;
  logic frame_start, frame_end, null_sample, res_sample;

  assign in_xfer     = (state == ST_XFER);
  assign frame_start = (state == ST_WAIT) && (gap_cnt == '0);
  assign null_sample = in_xfer && rise_evt && (bit_idx == NULL_I);
  assign res_sample  = in_xfer && rise_evt && (bit_idx > NULL_I);
  assign frame_end   = in_xfer && fall_evt && (bit_idx == LAST_I);

  adc3w_sclk_gen #(.DIV_W(DIV_W)) i_sclk_gen (
    .clk(clk), .rst_n(rst_n), .en(in_xfer), .div_half(div_half),
    .sclk(sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  adc3w_rx_shift #(.W(RES_W)) i_rx_shift (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .shift_en(res_sample),
    .din(sdata_i), .q(rx_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_idx  <= '0;
      cfg_q    <= '0;
      gap_cnt  <= GAP_W'(CS_HIGH_MIN);
      nerr_q   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      null_err <= 1'b0;
      cs_n     <= 1'b1;
      sdata_o  <= 1'b0;
      sdata_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          cfg_q <= cfg;
          busy  <= 1'b1;
          state <= ST_WAIT;
        end
        ST_WAIT: if (frame_start) begin
          cs_n     <= 1'b0;
          sdata_oe <= 1'b1;
          sdata_o  <= 1'b1;
          bit_idx  <= '0;
          nerr_q   <= 1'b0;
          state    <= ST_XFER;
        end
        default: begin
          if (null_sample) nerr_q <= sdata_i;
          if (frame_end) begin
            cs_n     <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b1;
            result   <= rx_q;
            null_err <= nerr_q;
            gap_cnt  <= GAP_W'(CS_HIGH_MIN);
            state    <= ST_IDLE;
          end else if (fall_evt) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx < CFG_I)
              sdata_o <= cmd_bit(8'(cfg_q), int'(bit_idx) + 1, CFG_W);
            else if (bit_idx == CFG_I)
              sdata_oe <= 1'b0;
          end
        end
      endcase
    end
  end

  // cycles chip select has been high, for the gap check
  logic [31:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cnt <= '0;
    else if (!cs_n)             hi_cnt <= '0;
    else if (hi_cnt != '1)      hi_cnt <= hi_cnt + 1'b1;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R1
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdata_oe); // R4
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !(!sclk && $past(sclk))) |-> $stable(sdata_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n)); // R7
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= 32'(CS_HIGH_MIN))); // R9
endmodule

// File: tb/test_adc3w_host.sv
module test_adc3w_host;
  localparam int DIV_W = 8, RES_W = 12, CFG_W = 3, GAP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] div_half = 8'd2;
  logic start = 1'b0;
  logic [CFG_W-1:0] cfg_in = '0;
  logic busy, done, null_err, cs_n, sclk, sdata_o, sdata_oe, bus;
  logic [RES_W-1:0] result;

  always #4 clk = ~clk;

  // converter model on a pulled-up line
  logic [RES_W-1:0] dev_val = '0;
  logic bad_null = 1'b0, dev_oe = 1'b0, dev_d = 1'b0, dev_start = 1'b0;
  logic [CFG_W-1:0] dev_cfg = '0;
  logic [5:0] rcnt = '0;
  assign bus = sdata_oe ? sdata_o : (dev_oe ? dev_d : 1'b1);

  adc3w_host #(.DIV_W(DIV_W), .RES_W(RES_W), .CFG_W(CFG_W), .CS_HIGH_MIN(GAP)) i_adc3w_host (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .start(start), .cfg(cfg_in),
    .busy(busy), .done(done), .result(result), .null_err(null_err),
    .cs_n(cs_n), .sclk(sclk), .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sdata_i(bus)
  );

  always @(posedge sclk or negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      rcnt <= '0; dev_oe <= 1'b0; dev_d <= 1'b0;
    end else if (sclk) begin
      if (rcnt == 0) dev_start <= bus;
      else if (rcnt <= 3) dev_cfg <= {dev_cfg[1:0], bus};
      rcnt <= rcnt + 1'b1;
    end else begin
      if (rcnt == 4) begin dev_oe <= 1'b1; dev_d <= bad_null; end
      else if (rcnt >= 5 && rcnt <= 16) dev_d <= dev_val[16 - rcnt];
      else if (rcnt > 16) dev_d <= 1'b0;
    end
  end

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitor
  int rise_cnt = 0, drive_cnt = 0, high_cyc = 0, hi_run = 0, last_gap = 0, viol = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_oe = 1'b0, p_sdo = 1'b0, p_done = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!cs_n && p_cs) begin
      last_gap = hi_run; rise_cnt = 0; drive_cnt = 0; high_cyc = 0;
    end
    if (cs_n) hi_run++; else hi_run = 0;
    if (!cs_n && sclk && !p_sclk) begin rise_cnt++; if (sdata_oe) drive_cnt++; end
    if (!cs_n && sclk) high_cyc++;
    if (cs_n && (sclk || sdata_oe)) viol++;                      // R1
    if (sdata_oe && dev_oe) viol++;                              // R4 contention
    if (!cs_n && !p_cs && sdata_oe && p_oe && !(!sclk && p_sclk) && sdata_o != p_sdo) viol++; // R3
    if (done && p_done) viol++;                                  // R7
    p_sclk = sclk; p_cs = cs_n; p_oe = sdata_oe; p_sdo = sdata_o; p_done = done;
  end

  function automatic int exp_high(input int d);
    return 17 * ((d == 0) ? 1 : d);
  endfunction

  task automatic launch(input logic [CFG_W-1:0] c, input logic [RES_W-1:0] v,
                        input int d, input bit bn);
    div_half = DIV_W'(d); cfg_in = c; dev_val = v; bad_null = bn; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
  endtask

  task automatic finish(input logic [CFG_W-1:0] c, input logic [RES_W-1:0] v,
                        input int d, input bit bn);
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R7 done seen", done, 1);
    chk(result == v, "R6 result", result, v);
    chk(null_err == bn, "R5 null_err", null_err, bn);
    chk(dev_start == 1'b1 && dev_cfg == c, "R2 start+cfg captured", {dev_start, dev_cfg}, {1'b1, c});
    chk(!busy && cs_n, "R7 busy low cs high at done", {busy, cs_n}, 1);
    chk(rise_cnt == 17, "R3 rising edges", rise_cnt, 17);
    chk(high_cyc == exp_high(d), "R3 half period", high_cyc, exp_high(d));
    chk(drive_cnt == 4, "R4 host-driven bits", drive_cnt, 4);
    chk(viol == 0, "R1/R3/R4/R7 monitor", viol, 0);
    viol = 0;
  endtask

  task automatic run_frame(input logic [CFG_W-1:0] c, input logic [RES_W-1:0] v,
                           input int d, input bit bn);
    @(negedge clk);
    launch(c, v, d, bn);
    finish(c, v, d, bn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !sdata_oe, "R1 reset idle", {cs_n, sclk, sdata_oe}, 3'b100);
    chk(!busy && !done, "R7 reset handshake", {busy, done}, 0);

    run_frame(3'b101, 12'hA5C, 2, 1'b0);
    run_frame(3'b010, 12'h001, 0, 1'b0);        // divider 0 acts as 1
    run_frame(3'b111, 12'h800, 1, 1'b1);        // null bit error
    run_frame(3'b000, 12'hFFF, 5, 1'b0);

    // R8: start during a frame is ignored
    @(negedge clk);
    launch(3'b110, 12'h3C3, 2, 1'b0);
    repeat (30) @(negedge clk);
    cfg_in = 3'b001; start = 1'b1; @(negedge clk); start = 1'b0;
    finish(3'b110, 12'h3C3, 2, 1'b0);
    repeat (20) @(negedge clk);
    chk(cs_n && !busy, "R8 no extra frame", {cs_n, busy}, 2'b10);

    // R9: back-to-back request in the done cycle
    @(negedge clk);
    launch(3'b011, 12'h123, 1, 1'b0);
    finish(3'b011, 12'h123, 1, 1'b0);
    launch(3'b100, 12'h456, 1, 1'b0);
    finish(3'b100, 12'h456, 1, 1'b0);
    chk(last_gap == GAP + 1, "R9 cs high gap", last_gap, GAP + 1);

    for (int k = 0; k < 20; k++) begin
      logic [CFG_W-1:0] c;
      logic [RES_W-1:0] v;
      int d;
      bit bn;
      c = CFG_W'($urandom);
      v = RES_W'($urandom);
      d = int'($urandom_range(0, 6));
      bn = ($urandom_range(0, 3) == 0);
      run_frame(c, v, d, bn);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule